// File: doc/BRIEF.md
# Periodic Second Insert/Swallow Corrector

This block trims the long-term drift of a seconds counter by whole seconds. It takes the raw once-per-second tick and turns each tick into an increment command for the downstream seconds counter. Most ticks produce an increment of one. Once every (period + 1) ticks, the block produces either zero, which drops a second, or two, which adds a second. Each such correction shifts the rate by 1e9/(period + 1) parts per billion.

Software sets up the block with one 32-bit adjust word. The word holds a 19-bit period in bits 18:0, a 2-bit mode in bits 20:19 and an enable bit in bit 23. Bits 31:24 and 22:21 are ignored. Any write to the word also restarts the internal phase counter.

The tick enters on a valid/ready pair and the increment command leaves on a valid/ready pair. A single output register sits between them. A tick is accepted only while `tick_ready` is high, and `tick_ready` is high exactly when the output register is empty or is being drained in the same cycle. While `inc_ready` is low, the pending command stays on the outputs unchanged. A tick offered while `tick_ready` is low is not taken and has no effect on the phase.

Top module: `sec_trim_corrector`

## Requirements
- R1: After reset, `inc_valid` is 0 and `tick_ready` is 1, and the block applies no correction until the adjust word is written with the enable bit (bit 23) set.
- R2: The adjust word is decoded as follows: period from bits 18:0, mode from bits 20:19, enable from bit 23. Bits 31:24 and 22:21 have no effect on any output.
- R3: While the enable bit is 0, every accepted tick produces an increment of 1.
- R4: With enable set and mode 2, the accepted tick that completes each group of (period+1) ticks produces an increment of 0. All other ticks produce 1. The increment value 3 never appears.
- R5: With enable set and mode 3, the accepted tick that completes each group of (period+1) ticks produces an increment of 2. All other ticks produce 1.
- R6: With enable set and mode 0 or mode 1, every accepted tick produces an increment of 1.
- R7: A write to the adjust word restarts the phase count. The first correction after the write falls on the (period+1)-th tick accepted after the write.
- R8: A tick accepted in the same cycle as a write is processed with the settings and phase that were in place before the write. The phase count after that cycle is 0.
- R9: An accepted tick's command appears on `inc_valid`/`inc_amount` at the next clock edge. It holds unchanged while `inc_ready` is low.
- R10: `tick_ready` is high exactly when `inc_valid` is low or `inc_ready` is high. A tick offered while `tick_ready` is low has no effect on the phase.
- R11: With period 0 and the enable bit set with mode 2 or mode 3, every accepted tick is corrected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the adjust word |
| cfg_wdata | input | 32 | Adjust word: period 18:0, mode 20:19, enable 23 |
| tick_valid | input | 1 | Raw one-second tick offered |
| tick_ready | output | 1 | Tick can be accepted this cycle |
| inc_valid | output | 1 | Increment command present |
| inc_ready | input | 1 | Downstream takes the command |
| inc_amount | output | 2 | Increment for the seconds counter: 0, 1 or 2 |

## Verification
An accepted tick's command is due at the first clock edge after acceptance. The bench drives inputs just after a falling edge and compares the outputs at the next falling edge, one rising edge later. The bench keeps its own model of the output register and of the phase count, updated once per cycle. With that model, every cycle's `inc_valid`, `inc_amount` and `tick_ready` are known before the comparison. This holds during stalls, when a write and a tick arrive together, and when ticks are refused. The comparison is made every cycle, not only on accepted ticks. This way the held command and a refused tick that must not move the phase are both checked.

// File: rtl/sec_adj_pkg.sv
package sec_adj_pkg;
  localparam int ADJ_REG_W    = 32;
  localparam int ADJ_PERIOD_W = 19;
  localparam int ADJ_MODE_LSB = 19;
  localparam int ADJ_MODE_W   = 2;
  localparam int ADJ_EN_BIT   = 23;
  localparam int ADJ_AMT_W    = 2;

  typedef enum logic [ADJ_MODE_W-1:0] {
    TRIM_NONE_A = 2'd0,
    TRIM_NONE_B = 2'd1,
    TRIM_DROP   = 2'd2,
    TRIM_ADD    = 2'd3
  } trim_mode_e;

  // Increment for one accepted tick, given the settings and whether the
  // phase counter wraps on this tick.
  function automatic logic [ADJ_AMT_W-1:0] trim_amount(
    input logic       en,
    input trim_mode_e mode,
    input logic       wrap
  );
    logic [ADJ_AMT_W-1:0] amt;
    amt = 2'd1;
    if (en && wrap) begin
      case (mode)
        TRIM_DROP: amt = 2'd0;
        TRIM_ADD:  amt = 2'd2;
        default:   amt = 2'd1;
      endcase
    end
    return amt;
  endfunction
endpackage

// File: rtl/sec_adj_cfg.sv
module sec_adj_cfg
  import sec_adj_pkg::*;
#(
  parameter int REG_W    = ADJ_REG_W,
  parameter int PERIOD_W = ADJ_PERIOD_W,
  parameter int MODE_LSB = ADJ_MODE_LSB,
  parameter int EN_BIT   = ADJ_EN_BIT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  output logic                cfg_en,
  output trim_mode_e          cfg_mode,
  output logic [PERIOD_W-1:0] cfg_period
);
  localparam int MODE_MSB = MODE_LSB + ADJ_MODE_W - 1;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{wr_data[REG_W-1:EN_BIT+1], wr_data[EN_BIT-1:MODE_MSB+1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_en     <= 1'b0;
      cfg_mode   <= TRIM_NONE_A;
      cfg_period <= '0;
    end else if (wr_en) begin
      cfg_en     <= wr_data[EN_BIT];
      cfg_mode   <= trim_mode_e'(wr_data[MODE_MSB:MODE_LSB]);
      cfg_period <= wr_data[PERIOD_W-1:0];
    end
  end
endmodule

// File: rtl/sec_adj_phase.sv
module sec_adj_phase #(
  parameter int PERIOD_W = 19
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                restart,
  input  logic [PERIOD_W-1:0] period,
  output logic                wrap
);
  localparam logic [PERIOD_W-1:0] ONE = {{(PERIOD_W-1){1'b0}}, 1'b1};

  logic [PERIOD_W-1:0] phase_q;

  assign wrap = step && (phase_q == period);

  always_ff @(posedge clk) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (step)    phase_q <= wrap ? '0 : phase_q + ONE;
  end
endmodule

// File: rtl/sec_adj_outreg.sv
module sec_adj_outreg #(
  parameter int AMT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [AMT_W-1:0] in_amt,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [AMT_W-1:0] out_amt
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_amt   <= 2'd1;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_amt <= in_amt;
    end
  end
endmodule

// File: rtl/sec_trim_corrector.sv
module sec_trim_corrector
  import sec_adj_pkg::*;
#(
  parameter int REG_W    = ADJ_REG_W,
  parameter int PERIOD_W = ADJ_PERIOD_W,
  parameter int MODE_LSB = ADJ_MODE_LSB,
  parameter int EN_BIT   = ADJ_EN_BIT,
  parameter int AMT_W    = ADJ_AMT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             tick_valid,
  output logic             tick_ready,
  output logic             inc_valid,
  input  logic             inc_ready,
  output logic [AMT_W-1:0] inc_amount
);
  logic                cfg_en;
  trim_mode_e          cfg_mode;
  logic [PERIOD_W-1:0] cfg_period;
  logic                tick_acc;
  logic                wrap;
  logic [AMT_W-1:0]    amt;

  assign tick_acc = tick_valid && tick_ready;

  sec_adj_cfg #(
    .REG_W(REG_W), .PERIOD_W(PERIOD_W), .MODE_LSB(MODE_LSB), .EN_BIT(EN_BIT)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .cfg_en(cfg_en), .cfg_mode(cfg_mode), .cfg_period(cfg_period)
  );

  sec_adj_phase #(.PERIOD_W(PERIOD_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .step(tick_acc), .restart(cfg_we),
    .period(cfg_period), .wrap(wrap)
  );

  assign amt = trim_amount(cfg_en, cfg_mode, wrap);

  sec_adj_outreg #(.AMT_W(AMT_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tick_valid), .in_ready(tick_ready), .in_amt(amt),
    .out_valid(inc_valid), .out_ready(inc_ready), .out_amt(inc_amount)
  );
endmodule

// File: rtl/sec_trim_checker.sv
module sec_trim_checker #(
  parameter int REG_W    = 32,
  parameter int MODE_LSB = 19,
  parameter int EN_BIT   = 23
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [REG_W-1:0] cfg_wdata,
  input logic             tick_valid,
  input logic             tick_ready,
  input logic             inc_valid,
  input logic             inc_ready,
  input logic [1:0]       inc_amount
);
  // Tracks from the port writes whether corrections are switched off.
  logic off_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      off_q <= 1'b1;
    else if (cfg_we) off_q <= !cfg_wdata[EN_BIT] || !cfg_wdata[MODE_LSB+1];
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) $rose(rst_n) |-> !inc_valid); // R1
  AST_OFF_GIVES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_valid && tick_ready && off_q) |=> (inc_amount == 2'd1)); // R3
  AST_AMOUNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    inc_valid |-> (inc_amount != 2'd3)); // R4
  AST_RESULT_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_valid && tick_ready) |=> inc_valid); // R9
  AST_HOLD_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_valid && !inc_ready) |=> (inc_valid && $stable(inc_amount))); // R9
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_valid |-> tick_ready); // R10
endmodule

bind sec_trim_corrector sec_trim_checker #(
  .REG_W(REG_W), .MODE_LSB(MODE_LSB), .EN_BIT(EN_BIT)
) u_sec_trim_checker (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .tick_valid(tick_valid), .tick_ready(tick_ready), .inc_valid(inc_valid),
  .inc_ready(inc_ready), .inc_amount(inc_amount)
);

// File: tb/sec_trim_corrector_bench.sv
module sec_trim_corrector_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        tick_valid = 1'b0;
  logic        tick_ready;
  logic        inc_valid;
  logic        inc_ready = 1'b1;
  logic [1:0]  inc_amount;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench model
  bit          m_en = 1'b0;
  int          m_mode = 0;
  int          m_period = 0;
  int          m_phase = 0;
  bit          m_ov = 1'b0;
  int          m_amt = 1;
  string       m_tag = "R1";

  always #2 clk = ~clk;

  sec_trim_corrector u_sec_trim_corrector (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tick_valid(tick_valid), .tick_ready(tick_ready), .inc_valid(inc_valid),
    .inc_ready(inc_ready), .inc_amount(inc_amount)
  );

  function automatic logic [31:0] mk_word(bit en, int mode, int period, logic [31:0] junk);
    logic [31:0] w;
    w = junk & 32'hFF60_0000;
    w[23] = en;
    w[20:19] = mode[1:0];
    w[18:0] = period[18:0];
    return w;
  endfunction

  function automatic int exp_amt(bit en, int mode, bit wrap);
    if (en && wrap && mode == 2) return 0;
    if (en && wrap && mode == 3) return 2;
    return 1;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One cycle: drive just after a falling edge, compare at the next one.
  task automatic cycle(bit tv, bit we, logic [31:0] wd, bit rdy);
    bit ready_now, acc, wrap;
    tick_valid = tv; cfg_we = we; cfg_wdata = wd; inc_ready = rdy;
    ready_now = !m_ov || rdy;
    acc = tv && ready_now;
    if (acc) begin
      wrap = (m_phase == m_period);
      m_amt = exp_amt(m_en, m_mode, wrap);
      if (!m_en) m_tag = "R3";
      else if (m_mode == 2) m_tag = (m_period == 0) ? "R11" : "R4";
      else if (m_mode == 3) m_tag = (m_period == 0) ? "R11" : "R5";
      else m_tag = "R6";
      if (we) m_tag = "R8";
      m_phase = wrap ? 0 : m_phase + 1;
    end
    if (ready_now) m_ov = acc;
    if (we) begin
      m_en = wd[23]; m_mode = int'(wd[20:19]); m_period = int'(wd[18:0]); m_phase = 0;
    end
    @(negedge clk);
    tick_valid = 1'b0; cfg_we = 1'b0;
    check("R9", int'(inc_valid), int'(m_ov), "inc_valid");
    if (m_ov) check(m_tag, int'(inc_amount), m_amt, "inc_amount");
    check("R10", int'(tick_ready), int'(!m_ov || inc_ready), "tick_ready");
  endtask

  task automatic wr(bit en, int mode, int period, logic [31:0] junk);
    cycle(1'b0, 1'b1, mk_word(en, mode, period, junk), 1'b1);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cycle(1'b1, 1'b0, '0, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd7734));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    check("R1", int'(inc_valid), 0, "inc_valid after reset");
    check("R1", int'(tick_ready), 1, "tick_ready after reset");
    m_tag = "R1";
    ticks(4);
    // R3: disabled with a drop mode in the word
    wr(1'b0, 2, 1, '0); ticks(5);
    // R4: drop every 3rd tick
    wr(1'b1, 2, 2, '0); ticks(7);
    // R5: add every 4th tick; R2: junk in ignored bits
    wr(1'b1, 3, 3, 32'hFFFF_FFFF); ticks(9);
    // R6: modes 0 and 1 with enable
    wr(1'b1, 0, 0, '0); ticks(3);
    wr(1'b1, 1, 0, 32'hA5A5_A5A5); ticks(3);
    // R11: period 0, every tick corrected
    wr(1'b1, 3, 0, '0); ticks(3);
    wr(1'b1, 2, 0, '0); ticks(3);
    // R7: rewrite mid-phase restarts the count
    wr(1'b1, 3, 4, '0); ticks(3);
    wr(1'b1, 3, 4, '0); ticks(6);
    // R8: tick together with a write uses the old settings
    wr(1'b1, 2, 1, '0); ticks(1);
    cycle(1'b1, 1'b1, mk_word(1'b1, 3, 2, '0), 1'b1);
    ticks(4);
    // R9/R10: stall, refused tick, then drain
    wr(1'b1, 2, 2, '0);
    cycle(1'b1, 1'b0, '0, 1'b0);
    cycle(1'b0, 1'b0, '0, 1'b0);
    cycle(1'b1, 1'b0, '0, 1'b0);   // refused: phase must not move
    cycle(1'b1, 1'b0, '0, 1'b0);
    cycle(1'b0, 1'b0, '0, 1'b1);
    ticks(4);
    // Random mix with stalls
    for (int k = 0; k < 400; k++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 8)
        cycle(1'b0, 1'b1, mk_word(1'($urandom_range(0, 1)), $urandom_range(0, 3),
              $urandom_range(0, 5), $urandom()), 1'b1);
      else if (r < 12)
        cycle(1'b1, 1'b1, mk_word(1'b1, $urandom_range(2, 3), $urandom_range(0, 4),
              $urandom()), 1'($urandom_range(0, 1)));
      else
        cycle(1'($urandom_range(0, 3) != 0), 1'b0, '0, 1'($urandom_range(0, 4) != 0));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule